// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns the bit stream on one asynchronous receive line into parallel characters. Timing comes from an oversampling tick enable. A mode input sets the tick rate to either sixteen or eight ticks per bit. Every bit time in the block is counted in those ticks.

While the line is idle, a high-to-low transition starts an internal tick counter. At the centre of the start bit the line is sampled again. If the line has gone back high, the event is a glitch: the receiver drops it and returns to idle. Otherwise each data bit, the optional parity bit and the stop bit are taken one full bit period apart, so each is sampled at its centre.

When the stop bit has been sampled, the assembled character appears for exactly one clock cycle, together with its flags for parity error, framing error and break. Three configuration inputs set the word length (5 to 8 bits), turn parity on or off, and choose odd or even parity.

Top module: `serial_rx_deser`

## Requirements
- R1: After synchronous reset, `char_valid`, `par_fault`, `frm_fault` and `brk_seen` are 0 and the receiver is idle, waiting for a start edge.
- R2: `os_eight` = 0 selects 16 ticks per bit and `os_eight` = 1 selects 8 ticks per bit. Characters whose bits last that many `os_tick` pulses are received correctly in both modes.
- R3: The start bit is sampled again 8 ticks (16x mode) or 4 ticks (8x mode) after the tick that saw the falling edge. If the line is high at that sample, no character is produced and the receiver waits for a new falling edge.
- R4: Data bits arrive least significant bit first. Each one is sampled one full bit period (16 or 8 ticks) after the previous sample.
- R5: `word_sel` gives the number of data bits: 00 = 5, 01 = 6, 10 = 7, 11 = 8. In `char_out`, the bits at and above the word length are 0.
- R6: When `par_on` = 1, one parity bit follows the last data bit. `par_odd` = 1 means the data bits plus the parity bit hold an odd number of ones; `par_odd` = 0 means an even number. A mismatch sets `par_fault`. When `par_on` = 0, no parity bit is expected and `par_fault` stays 0.
- R7: `frm_fault` is set when the stop bit is sampled low.
- R8: `brk_seen` is set when all data bits, the parity bit (if enabled) and the stop bit are sampled low. `frm_fault` is set alongside it.
- R9: After a character with a low stop bit, the receiver does not start a new character until the line has been seen high at a tick.
- R10: `char_valid` is high for exactly one clock cycle, the cycle after the stop-bit sample. The three flags describe that character during that cycle only and are 0 whenever `char_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick enable, one clock wide |
| os_eight | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| word_sel | input | 2 | Data bit count select (5 to 8) |
| par_on | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_line | input | 1 | Serial input, already synchronous to clk |
| char_out | output | 8 | Received character, zero-extended |
| char_valid | output | 1 | One-cycle strobe for a new character |
| par_fault | output | 1 | Parity mismatch for this character |
| frm_fault | output | 1 | Stop bit sampled low |
| brk_seen | output | 1 | All-zero frame including the stop bit |

## Verification
The hardest behaviour to reach is the wait for an idle line after a frame ends with its stop bit low. From the ports it looks exactly like doing nothing. To reach it, the stimulus sends a frame with a low stop bit and then holds the line low for many bit times; any character reported in that window is an error. A correct frame sent afterwards must be received cleanly. False starts are handled the same way: the stimulus gives a low pulse shorter than half a bit, then sends a good character that must arrive intact.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int MAX_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                valid;
        logic                perr;
        logic                ferr;
        logic                brk;
    } rx_result_t;

    function automatic logic [3:0] word_bits(input logic [1:0] wl);
        return 4'd5 + {2'b00, wl};
    endfunction

    function automatic logic [MAX_BITS-1:0] word_mask(input logic [1:0] wl);
        return 8'hFF >> (4'd8 - word_bits(wl));
    endfunction

    function automatic logic parity_bad(input logic [MAX_BITS-1:0] d,
                                        input logic pbit, input logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/rx_tick_timer.sv
module rx_tick_timer #(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    input  logic low_rate,
    input  logic half,
    output logic hit
);
    localparam int CW = $clog2(OSR_HI);

    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    always_comb begin
        if (low_rate) target = half ? CW'(OSR_LO/2 - 1) : CW'(OSR_LO - 1);
        else          target = half ? CW'(OSR_HI/2 - 1) : CW'(OSR_HI - 1);
    end

    assign hit = tick && !clr && (cnt == target);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= hit ? '0 : cnt + 1'b1;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (low_rate && !half) |-> (cnt < CW'(OSR_LO))) else $error("cnt range"); // R2

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  logic       hit,
    input  logic [1:0] wl,
    input  logic       par_en,
    input  logic       odd,
    output logic       clr,
    output logic       half,
    output rx_result_t res
);
    rx_state_e           state;
    logic                last_rx;
    logic [2:0]          bidx;
    logic [MAX_BITS-1:0] shreg;
    logic                pbit;

    assign clr  = (state == ST_IDLE) || (state == ST_HOLD);
    assign half = (state == ST_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            last_rx <= 1'b1;
            bidx    <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            res     <= '0;
        end else begin
            res.valid <= 1'b0;
            res.perr  <= 1'b0;
            res.ferr  <= 1'b0;
            res.brk   <= 1'b0;
            case (state)
                ST_IDLE: if (tick) begin
                    last_rx <= rx;
                    if (last_rx && !rx) state <= ST_START;
                end
                ST_START: if (hit) begin
                    if (rx) begin
                        state   <= ST_IDLE;
                        last_rx <= 1'b1;
                    end else begin
                        state <= ST_DATA;
                        bidx  <= '0;
                        shreg <= '0;
                        pbit  <= 1'b0;
                    end
                end
                ST_DATA: if (hit) begin
                    shreg[bidx] <= rx;
                    bidx        <= bidx + 1'b1;
                    if ({1'b0, bidx} == word_bits(wl) - 4'd1)
                        state <= par_en ? ST_PAR : ST_STOP;
                end
                ST_PAR: if (hit) begin
                    pbit  <= rx;
                    state <= ST_STOP;
                end
                ST_STOP: if (hit) begin
                    res.data  <= shreg;
                    res.valid <= 1'b1;
                    res.ferr  <= !rx;
                    res.perr  <= par_en && parity_bad(shreg, pbit, odd);
                    res.brk   <= !rx && (shreg == '0) && !(par_en && pbit);
                    last_rx   <= rx;
                    state     <= rx ? ST_IDLE : ST_HOLD;
                end
                ST_HOLD: if (tick && rx) begin
                    state   <= ST_IDLE;
                    last_rx <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && hit && rx) |=> (state == ST_IDLE)) else $error("false start"); // R3
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !rx) |=> (state == ST_HOLD)) else $error("hold"); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        res.valid |=> !res.valid) else $error("valid pulse"); // R10
    AST_FLAG_QUAL: assert property (@(posedge clk) disable iff (rst)
        (res.perr || res.ferr || res.brk) |-> res.valid) else $error("flag qual"); // R10
    AST_BREAK_FRAME: assert property (@(posedge clk) disable iff (rst)
        res.brk |-> (res.ferr && res.data == '0)) else $error("break"); // R8

endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
    import serial_rx_pkg::*;
#(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       os_eight,
    input  logic [1:0] word_sel,
    input  logic       par_on,
    input  logic       par_odd,
    input  logic       rx_line,
    output logic [7:0] char_out,
    output logic       char_valid,
    output logic       par_fault,
    output logic       frm_fault,
    output logic       brk_seen
);
    logic       hit, clr, half;
    rx_result_t res;

    rx_tick_timer #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO)) u_timer (
        .clk(clk), .rst(rst), .tick(os_tick), .clr(clr),
        .low_rate(os_eight), .half(half), .hit(hit)
    );

    rx_frame_fsm u_fsm (
        .clk(clk), .rst(rst), .tick(os_tick), .rx(rx_line), .hit(hit),
        .wl(word_sel), .par_en(par_on), .odd(par_odd),
        .clr(clr), .half(half), .res(res)
    );

    assign char_out   = res.data;
    assign char_valid = res.valid;
    assign par_fault  = res.perr;
    assign frm_fault  = res.ferr;
    assign brk_seen   = res.brk;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> ((char_out & ~word_mask(word_sel)) == 8'h00)) else $error("upper"); // R5

endmodule

// File: tb/serial_rx_deser_test.sv
`timescale 1ns/1ps
module serial_rx_deser_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       os_eight = 1'b0;
    logic [1:0] word_sel = 2'b11;
    logic       par_on = 1'b0;
    logic       par_odd = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] char_out;
    logic       char_valid, par_fault, frm_fault, brk_seen;

    int n_checks = 0;
    int n_fail   = 0;
    int ev_cnt   = 0;
    int pulse_bad = 0;
    int flag_bad  = 0;
    logic       prev_valid = 1'b0;
    logic [7:0] cap_data;
    logic       cap_perr, cap_ferr, cap_brk;
    bit         done = 1'b0;
    int         phase = 0;

    serial_rx_deser uut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .os_eight(os_eight),
        .word_sel(word_sel), .par_on(par_on), .par_odd(par_odd),
        .rx_line(rx_line), .char_out(char_out), .char_valid(char_valid),
        .par_fault(par_fault), .frm_fault(frm_fault), .brk_seen(brk_seen)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        phase   <= (phase + 1) % 2;
        os_tick <= (phase == 1);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (char_valid) begin
                ev_cnt   <= ev_cnt + 1;
                cap_data <= char_out;
                cap_perr <= par_fault;
                cap_ferr <= frm_fault;
                cap_brk  <= brk_seen;
            end
            if (char_valid && prev_valid) pulse_bad <= pulse_bad + 1;
            if (!char_valid && (par_fault || frm_fault || brk_seen)) flag_bad <= flag_bad + 1;
            prev_valid <= char_valid;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_ticks(input int n);
        repeat (n) @(posedge clk iff os_tick);
        @(negedge clk);
    endtask

    function automatic int osr();
        return os_eight ? 8 : 16;
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic pb, input logic stopb);
        int nb;
        nb = 5 + int'(word_sel);
        rx_line = 1'b0;
        hold_ticks(osr());
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i];
            hold_ticks(osr());
        end
        if (par_on) begin
            rx_line = pb;
            hold_ticks(osr());
        end
        rx_line = stopb;
        hold_ticks(osr());
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int k;
        logic [7:0] d, m;
        logic pb, bad;
        int base;
        repeat (4) @(negedge clk);
        check("R1 valid", char_valid, 0);
        check("R1 flags", {par_fault, frm_fault, brk_seen}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 idle no event", ev_cnt, 0);

        k = 0;
        for (int md = 0; md < 2; md++)
            for (int wl = 0; wl < 4; wl++)
                for (int pe = 0; pe < 2; pe++)
                    for (int po = 0; po < 2; po++)
                        for (int v = 0; v < 3; v++) begin
                            os_eight = md[0]; word_sel = wl[1:0];
                            par_on = pe[0]; par_odd = po[0];
                            d = 8'((k * 37 + 91) ^ (v * 8'h5A));
                            m = 8'hFF >> (3 - wl);
                            bad = pe[0] && (v == 1);
                            pb = (^(d & m)) ^ po[0] ^ bad;
                            base = ev_cnt;
                            send_frame(d, pb, 1'b1);
                            hold_ticks(2 * osr());
                            check("R2 R10 one char", ev_cnt - base, 1);
                            check("R4 R5 data", cap_data, d & m);
                            check("R6 parity", cap_perr, bad);
                            check("R7 frame ok", cap_ferr, 0);
                            k++;
                        end

        // R3: short low pulse, then good char
        os_eight = 1'b0; word_sel = 2'b11; par_on = 1'b0; par_odd = 1'b0;
        base = ev_cnt;
        rx_line = 1'b0; hold_ticks(3);
        rx_line = 1'b1; hold_ticks(64);
        check("R3 false start ignored", ev_cnt - base, 0);
        send_frame(8'hC3, 1'b0, 1'b1); hold_ticks(32);
        check("R3 recovers", cap_data, 8'hC3);
        os_eight = 1'b1;
        base = ev_cnt;
        rx_line = 1'b0; hold_ticks(2);
        rx_line = 1'b1; hold_ticks(40);
        check("R3 false start 8x", ev_cnt - base, 0);

        // R7 R9: framing error, then line held low
        os_eight = 1'b0; word_sel = 2'b10;
        base = ev_cnt;
        send_frame(8'h15, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 ferr", cap_ferr, 1);
        check("R8 no brk", cap_brk, 0);
        hold_ticks(16 * 40);
        check("R9 no restart while low", ev_cnt - base, 1);
        rx_line = 1'b1; hold_ticks(32);
        send_frame(8'h2A, 1'b0, 1'b1); hold_ticks(32);
        check("R9 resume data", cap_data, 8'h2A);
        check("R9 resume ferr", cap_ferr, 0);

        // R8: break with even parity enabled
        word_sel = 2'b11; par_on = 1'b1; par_odd = 1'b0;
        send_frame(8'h00, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 brk", cap_brk, 1);
        check("R8 ferr", cap_ferr, 1);
        check("R8 perr", cap_perr, 0);
        rx_line = 1'b1; hold_ticks(32);
        // not break: parity bit high
        par_odd = 1'b1;
        send_frame(8'h00, 1'b1, 1'b0);
        @(negedge clk);
        check("R8 pbit high no brk", cap_brk, 0);
        rx_line = 1'b1; hold_ticks(32);

        check("R10 pulse width", pulse_bad, 0);
        check("R10 flags only with valid", flag_bad, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule